// File: doc/BRIEF.md
# Two-Wire Slave Address Recognizer

This block listens to a two-wire serial bus and decides whether the local device is being addressed. Clock and data pass through multi-flop synchronizers, and edge logic finds START, repeated START and STOP conditions. After a START the block shifts in eight bits, most significant first, on rising clock edges: a 7-bit address followed by the read/write bit. A comparator then checks the address against a programmable own address. The check skips every bit position that the ignore mask selects. When the enable is set, the comparator also accepts the general-call address of zero.

On a hit, the block pulls the data line low for the acknowledge clock and sets a sticky interrupt flag. It also records the read/write bit and whether the hit was a general call. On a miss, it stays off the bus until the next START or STOP. A small register port holds the own address, the mask and the flag. The block handles only the address phase. Data bytes, master operation and arbitration belong to other logic.

The controller has five states:
- IDLE: waiting for a START.
- SHIFT: collecting the eight bits.
- DECIDE: waiting for the falling clock edge after bit eight.
- ACK: holding the data line low.
- IGNORE: passive until the next START or STOP.

Transitions:
- STOP moves any state to IDLE.
- START or repeated START moves any state to SHIFT.
- SHIFT moves to DECIDE on the eighth rising edge.
- DECIDE moves on the next falling edge, to ACK on a hit and to IGNORE otherwise.
- ACK moves to IGNORE on the falling edge that ends the ninth clock.

Top module: `twi_addr_match`

## Requirements
- R1: After reset, register 0 reads 0xFE, register 1 reads 0x00, register 2 reads 0x00, and both `irq` and `sda_pull` are 0.
- R2: Register 0 (index 0) holds the 7-bit own address in bits 7:1 and the general-call enable in bit 0. Register 1 (index 1) holds the ignore mask in bits 7:1, and its bit 0 always reads 0.
- R3: With the enable set, the address 0x00 is a hit whatever the own address, and `match_gc` becomes 1. With the enable clear, 0x00 is a hit only through the own-address comparison, and `match_gc` becomes 0.
- R4: An address bit whose mask bit is 1 never causes a miss. Any differing unmasked bit causes a miss.
- R5: On a hit, `sda_pull` is 1 from the falling clock edge after bit eight until the falling edge that ends the ninth clock. It does not change while SCL is high. On a miss, it stays 0.
- R6: A hit sets `irq`. The flag then stays 1 until software writes a 1 to bit 0 of register 2.
- R7: On a hit, `rw_bit` takes the eighth received bit. Register 2 reports the flag in bit 0, the read/write bit in bit 1 and the general-call indication in bit 2.
- R8: Bits clocked without a preceding START are ignored. A STOP in the middle of the address returns the block to idle, so later bits without a new START raise no acknowledge.
- R9: A repeated START in the middle of an address discards the partial address and begins a new collection.
- R10: After a miss, the block raises no acknowledge for later bytes until a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = drive the data line low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 own address, 1 mask, 2 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Sticky address-hit flag |
| rw_bit | output | 1 | Read/write bit of the last hit |
| match_gc | output | 1 | 1 when the last hit was a general call |

## Verification
Some properties are checked on every cycle:
- The flag cannot drop without a clear write.
- The flag rises only together with the acknowledge drive.
- The acknowledge drive stays constant while SCL is high.
- A general-call hit needs the enable bit.

Other behaviour only the bench scenarios can show. This covers the mask and general-call decisions for specific addresses and the exact acknowledge window. It also covers rejection of bits without START, abort on STOP, restart on a repeated START and passivity after a miss.

// File: rtl/twi_am_pkg.sv
package twi_am_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DECIDE,
        ST_ACK,
        ST_IGNORE
    } am_state_t;

    localparam logic [1:0] REG_OWN  = 2'd0;
    localparam logic [1:0] REG_MASK = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
endpackage

// File: rtl/twi_am_sync.sv
module twi_am_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_in};
            sda_p <= {sda_p[STAGES-2:0], sda_in};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_am_cmp.sv
module twi_am_cmp #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] own,
    input  logic [AW-1:0] mask,
    input  logic          gc_en,
    output logic          hit,
    output logic          is_gc
);
    logic [AW-1:0] bit_ok;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | (addr[i] == own[i]);
    end

    assign is_gc = gc_en & (addr == '0);
    assign hit   = is_gc | (&bit_ok);
endmodule

// File: rtl/twi_am_fsm.sv
module twi_am_fsm
    import twi_am_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            hit,
    output logic [BITS-1:0] frame,
    output logic            ack_go,
    output logic            sda_pull
);
    localparam int CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    am_state_t       state_q, state_d;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            frame <= '0;
        end else if (start_det) begin
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT && scl_rise) begin
            frame <= {frame[BITS-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_SHIFT;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SHIFT:  if (scl_rise && cnt_q == LAST) state_d = ST_DECIDE;
                ST_DECIDE: if (scl_fall) state_d = hit ? ST_ACK : ST_IGNORE;
                ST_ACK:    if (scl_fall) state_d = ST_IGNORE;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_pull = (state_q == ST_ACK);
        ack_go   = (state_q == ST_DECIDE) && (state_d == ST_ACK);
    end
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match
    import twi_am_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       rw_bit,
    output logic       match_gc
);
    localparam int RW = ADDR_W + 1;

    logic [RW-1:0]     own_q;
    logic [ADDR_W-1:0] mask_q;
    logic [RW-1:0]     frame;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              hit, is_gc, ack_go, clr_req;

    twi_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_am_cmp #(.AW(ADDR_W)) u_cmp (
        .addr  (frame[RW-1:1]),
        .own   (own_q[RW-1:1]),
        .mask  (mask_q),
        .gc_en (own_q[0]),
        .hit   (hit),
        .is_gc (is_gc)
    );

    twi_am_fsm #(.BITS(RW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .hit       (hit),
        .frame     (frame),
        .ack_go    (ack_go),
        .sda_pull  (sda_pull)
    );

    assign clr_req = reg_we && (reg_addr == REG_STAT) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q  <= {{ADDR_W{1'b1}}, 1'b0};
            mask_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == REG_OWN)  own_q  <= reg_wdata[RW-1:0];
            if (reg_addr == REG_MASK) mask_q <= reg_wdata[RW-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            rw_bit   <= 1'b0;
            match_gc <= 1'b0;
        end else if (ack_go) begin
            irq      <= 1'b1;
            rw_bit   <= frame[0];
            match_gc <= is_gc;
        end else if (clr_req) begin
            irq      <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_OWN:  reg_rdata = 8'(own_q);
            REG_MASK: reg_rdata = 8'({mask_q, 1'b0});
            REG_STAT: reg_rdata = {5'b0, match_gc, rw_bit, irq};
            default:  reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/twi_am_chk.sv
module twi_am_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic irq,
    input logic sda_pull,
    input logic match_gc,
    input logic clr_req,
    input logic gce
);
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_req |=> irq); // R6

    AST_IRQ_WITH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> sda_pull); // R6

    AST_PULL_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> irq); // R5

    AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_in && $past(scl_in) |-> $stable(sda_pull)); // R5

    AST_GC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && match_gc |-> $past(gce)); // R3
endmodule

bind twi_addr_match twi_am_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .irq      (irq),
    .sda_pull (sda_pull),
    .match_gc (match_gc),
    .clr_req  (reg_we && (reg_addr == 2'd2) && reg_wdata[0]),
    .gce      (own_q[0])
);

// File: tb/sim_twi_addr_match.sv
`timescale 1ns/1ps
module sim_twi_addr_match;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_pull, reg_we = 1'b0, irq, rw_bit, match_gc;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       sda_bus;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    twi_addr_match u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .sda_pull  (sda_pull),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .rw_bit    (rw_bit),
        .match_gc  (match_gc)
    );

    // own(8) mask(8) addr(7) rw(1) exp_ack(1) exp_gc(1)
    localparam logic [25:0] VEC [0:8] = '{
        {8'hA0, 8'h00, 7'h50, 1'b0, 1'b1, 1'b0},
        {8'hA0, 8'h00, 7'h51, 1'b1, 1'b0, 1'b0},
        {8'hA0, 8'h06, 7'h53, 1'b1, 1'b1, 1'b0},
        {8'hA0, 8'h06, 7'h54, 1'b0, 1'b0, 1'b0},
        {8'hA1, 8'h00, 7'h00, 1'b0, 1'b1, 1'b1},
        {8'hA0, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0},
        {8'h00, 8'h00, 7'h00, 1'b1, 1'b1, 1'b0},
        {8'hFE, 8'hFE, 7'h2A, 1'b1, 1'b1, 1'b0},
        {8'h01, 8'h00, 7'h00, 1'b1, 1'b1, 1'b1}
    };

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        wait_q(4);
        rst_n = 1'b1;
        wait_q(4);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    // eight bits plus the acknowledge clock; scl is low on entry and exit
    task automatic clock9(input logic [7:0] b, output int pre, output int ack, output int post);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        pre = int'(sda_pull);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q / 2);
        ack = int'(sda_pull & ~sda_bus);
        wait_q(Q / 2);
        scl_m = 1'b0; wait_q(Q);
        post = int'(sda_pull);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, pre, ack, post;
        do_reset();

        // table walk: R3 R4 R5 R6 R7
        for (int k = 0; k < 9; k++) begin
            logic [25:0] e;
            e = VEC[k];
            wr(2'd0, e[25:18]);
            wr(2'd1, e[17:10]);
            wr(2'd2, 8'h01);
            start_c();
            clock9({e[9:3], e[2]}, pre, ack, post);
            stop_c();
            chk($sformatf("R4 vec%0d ack", k), ack, int'(e[1]));
            chk($sformatf("R5 vec%0d pull before ninth clock", k), pre, int'(e[1]));
            chk($sformatf("R5 vec%0d released after ninth clock", k), post, 0);
            chk($sformatf("R6 vec%0d irq", k), int'(irq), int'(e[1]));
            if (e[1]) begin
                chk($sformatf("R3 vec%0d match_gc", k), int'(match_gc), int'(e[0]));
                chk($sformatf("R7 vec%0d rw_bit", k), int'(rw_bit), int'(e[2]));
                rd(2'd2, v);
                chk($sformatf("R7 vec%0d status", k), v, int'({e[0], e[2], 1'b1}));
            end
        end

        // R1: reset values
        do_reset();
        rd(2'd0, v); chk("R1 own reset", v, 8'hFE);
        rd(2'd1, v); chk("R1 mask reset", v, 8'h00);
        rd(2'd2, v); chk("R1 status reset", v, 8'h00);
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 pull reset", int'(sda_pull), 0);

        // R2: register layout
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 mask bit0 reads 0", v, 8'hFE);
        wr(2'd0, 8'h37); rd(2'd0, v); chk("R2 own readback", v, 8'h37);
        wr(2'd0, 8'hFE); wr(2'd1, 8'h00);

        // R8: bits without START
        scl_m = 1'b0; wait_q(Q);
        clock9(8'hFE, pre, ack, post);
        chk("R8 no ack without start", ack, 0);
        chk("R8 no irq without start", int'(irq), 0);
        stop_c();

        // R8: STOP mid-address returns to idle
        start_c();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        stop_c();
        scl_m = 1'b0; wait_q(Q);
        clock9(8'hFE, pre, ack, post);
        chk("R8 no ack after stop", ack, 0);
        stop_c();

        // R10: miss then passive
        start_c();
        clock9(8'h20, pre, ack, post);
        chk("R10 miss no ack", ack, 0);
        clock9(8'hFE, pre, ack, post);
        chk("R10 passive after miss", ack, 0);
        chk("R10 no irq", int'(irq), 0);
        stop_c();

        // R9: repeated START restarts collection
        start_c();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        start_c();
        clock9(8'hFF, pre, ack, post);
        chk("R9 ack after repeated start", ack, 1);
        chk("R7 rw after repeated start", int'(rw_bit), 1);
        stop_c();

        // R6: sticky flag until cleared
        wait_q(50);
        chk("R6 irq sticky after stop", int'(irq), 1);
        wr(2'd2, 8'h00);
        chk("R6 write of 0 keeps irq", int'(irq), 1);
        wr(2'd2, 8'h01);
        chk("R6 irq cleared", int'(irq), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule